// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

The block keeps an alarm time made of four byte registers, one each for seconds, minutes, hours and day of month. An external timekeeping counter supplies the current time in BCD together with a strobe that pulses once per second. On each strobe the block compares the alarm against the time. When they agree, it emits a one-cycle interrupt pulse, provided the alarm enable bit is set.

The top bit of every alarm register is a repeat mask that removes that field from the comparison. Only a nested set of mask patterns is honoured. With no masks the alarm fires once a month. Masking the date gives a daily alarm. Masking date and hours gives an hourly alarm. Masking date, hours and minutes gives an alarm every minute. Every other pattern makes the alarm fire on every strobe. Writes that carry an out-of-range BCD value are dropped, so the stored alarm stays the same.

Top module: `alarm_cmp`

## Requirements
- R1: After reset all four alarm registers and the enable bit read zero and irq_o is low.
- R2: Offsets 0, 1, 2 and 3 hold alarm seconds, minutes, hours and date, and read back the full stored byte including bit 7. Offset 4 holds the enable in bit 0 and reads zero in bits 7:1. Offsets 5 to 7 read zero, and writes to them change nothing.
- R3: A write to the seconds or minutes register is stored only if bits 6:4 times ten plus bits 3:0 is at most 59. Any other write leaves the register unchanged.
- R4: A write to the hours register is stored only if bits 5:4 times ten plus bits 3:0 is at most 23.
- R5: A write to the date register is stored only if bits 5:4 times ten plus bits 3:0 is non-zero.
- R6: When no mask bit (bit 7) is set, a strobe fires only if seconds[6:0], minutes[6:0], hours[5:0] and date[5:0] all equal the time inputs.
- R7: With only the date mask set, seconds, minutes and hours must match. With date and hours masked, seconds and minutes must match. With date, hours and minutes masked, only seconds must match.
- R8: Every other mask pattern fires on every strobe, whatever the time.
- R9: irq_o is high for exactly the one cycle after a firing strobe. Without a strobe it stays low, even while the time matches.
- R10: While the enable bit is clear, irq_o stays low.
- R11: An accepted alarm write takes effect from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | One-second strobe |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD |
| date_i | input | 6 | Current day of month, BCD |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
Every one of the 256 byte values is written to each alarm register, and the read-back is compared with an acceptance rule computed in the bench. A design that checks the wrong bits, or that accepts units digits above nine or dates of zero differently, shows a mismatch. All 16 mask patterns are then crossed with all 16 combinations of matching and non-matching fields. This catches a decoder that treats a non-nested pattern as a narrower repeat, or that compares a masked field. Separate cases cover a match held without a strobe, an alarm with the enable cleared, and a rewrite of the alarm followed straight away by a strobe. These would show up as stray pulses, stretched pulses or a stale comparison.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW     = 8;
  localparam int SEC_W  = 7;
  localparam int HR_W   = 6;
  localparam int NFIELD = 4;

  typedef enum logic [2:0] {
    RPT_MONTH, RPT_DAY, RPT_HOUR, RPT_MIN, RPT_SEC
  } rpt_e;

  // tens in [6:4], units in [3:0]; max 85 fits 7 bits
  function automatic logic [6:0] bcd2bin(input logic [6:0] b);
    return 7'(b[6:4]) * 7'd10 + 7'(b[3:0]);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NFIELD-1:0][DW-1:0] alm_o,
  output logic                      en_o,
  output logic [DW-1:0]             rdata_o
);
  localparam int EN_OFS = NFIELD;

  logic [NFIELD-1:0] ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam logic [6:0] VMASK = (i < 2) ? 7'h7F : 7'h3F;
    localparam int unsigned VMAX = (i < 2) ? 59 : 23;
    logic [6:0] val;
    assign val = bcd2bin(wdata_i[6:0] & VMASK);
    if (i == NFIELD - 1) begin : g_date
      assign ok[i] = (val != 7'd0);
    end else begin : g_lim
      assign ok[i] = (32'(val) <= VMAX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_o[i] <= '0;
      else if (we_i && 32'(addr_i) == i && ok[i]) alm_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else if (we_i && 32'(addr_i) == EN_OFS) en_o <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (32'(addr_i) < NFIELD) rdata_o = alm_o[addr_i[1:0]];
    else if (32'(addr_i) == EN_OFS) rdata_o = {{(DW-1){1'b0}}, en_o};
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic [NFIELD-1:0][DW-1:0] alm_i,
  input  logic [SEC_W-1:0]          sec_i,
  input  logic [SEC_W-1:0]          min_i,
  input  logic [HR_W-1:0]           hour_i,
  input  logic [HR_W-1:0]           date_i,
  output rpt_e                      mode_o,
  output logic                      fire_o
);
  logic [NFIELD-1:0][SEC_W-1:0] now;
  logic [NFIELD-1:0]            eq;
  logic [NFIELD-1:0]            msk;

  assign now[0] = sec_i;
  assign now[1] = min_i;
  assign now[2] = 7'(hour_i);
  assign now[3] = 7'(date_i);

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    localparam int W = (i < 2) ? SEC_W : HR_W;
    assign eq[i]  = (alm_i[i][W-1:0] == now[i][W-1:0]);
    assign msk[i] = alm_i[i][DW-1];
  end

  // only nested patterns narrow the compare; rest run every tick
  always_comb begin
    unique case (msk)
      4'b0000: mode_o = RPT_MONTH;
      4'b1000: mode_o = RPT_DAY;
      4'b1100: mode_o = RPT_HOUR;
      4'b1110: mode_o = RPT_MIN;
      default: mode_o = RPT_SEC;
    endcase
  end

  always_comb begin
    unique case (mode_o)
      RPT_MONTH: fire_o = &eq;
      RPT_DAY:   fire_o = &eq[2:0];
      RPT_HOUR:  fire_o = &eq[1:0];
      RPT_MIN:   fire_o = eq[0];
      default:   fire_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [SEC_W-1:0]  min_i,
  input  logic [HR_W-1:0]   hour_i,
  input  logic [HR_W-1:0]   date_i,
  output logic              irq_o
);
  logic [NFIELD-1:0][DW-1:0] alm_q;
  logic                      alm_en;
  rpt_e                      mode;
  logic                      fire;
  logic                      irq_q;

  alarm_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .alm_o   (alm_q),
    .en_o    (alm_en),
    .rdata_o (rdata_o)
  );

  alarm_match i_match (
    .alm_i  (alm_q),
    .sec_i  (sec_i),
    .min_i  (min_i),
    .hour_i (hour_i),
    .date_i (date_i),
    .mode_o (mode),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= tick_i & alm_en & fire;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic                      tick_i,
  input logic                      irq_o,
  input logic                      en_q,
  input logic [NFIELD-1:0][DW-1:0] alm_q
);
  a_r9_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_o);

  a_r3_sec_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && bcd2bin(wdata_i[6:0]) > 7'd59) |=> $stable(alm_q[0]));

  a_r5_date_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(addr_i) == 3 && wdata_i[5:0] == 6'd0) |=> $stable(alm_q[3]));
endmodule

bind alarm_cmp alarm_chk #(.ADDR_W(ADDR_W)) i_alarm_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (tick_i),
  .irq_o   (irq_o),
  .en_q    (alm_en),
  .alm_q   (alm_q)
);

// File: tb/test_alarm_cmp.sv
module test_alarm_cmp;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tick_i = 1'b0;
  logic [6:0] sec_i = '0, min_i = '0;
  logic [5:0] hour_i = '0, date_i = '0;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [4];
  logic [7:0] base [4] = '{8'h30, 8'h15, 8'h12, 8'h21};

  always #10 clk_i = ~clk_i;

  alarm_cmp #(.ADDR_W(3)) i_alarm_cmp (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 3'(a); wdata_i = 8'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr_i = 3'(a);
    #1;
    d = int'(rdata_o);
  endtask

  // strobe for one cycle; irq sampled at the following negedge
  task automatic tick(input int s, input int m, input int h, input int d, output int irq);
    @(negedge clk_i);
    sec_i = 7'(s); min_i = 7'(m); hour_i = 6'(h); date_i = 6'(d); tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    irq = int'(irq_o);
  endtask

  function automatic bit accept(input int a, input int v);
    int u = v & 15;
    if (a < 2) return (((v >> 4) & 7) * 10 + u) <= 59;
    if (a == 2) return (((v >> 4) & 3) * 10 + u) <= 23;
    return (((v >> 4) & 3) * 10 + u) != 0;
  endfunction

  function automatic bit exp_fire(input int p, input int c);
    case (p)
      0:  return c == 15;
      8:  return (c & 7) == 7;
      12: return (c & 3) == 3;
      14: return (c & 1) == 1;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v, q;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check("R1", v, 0);
    end
    check("R1", int'(irq_o), 0);

    // R3 R4 R5 full byte sweep per register
    for (int a = 0; a < 4; a++) begin
      mdl[a] = 8'h00;
      for (int d = 0; d < 256; d++) begin
        wr(a, d);
        if (accept(a, d)) mdl[a] = 8'(d);
        rd(a, v);
        check(a < 2 ? "R3" : (a == 2 ? "R4" : "R5"), v, int'(mdl[a]));
      end
    end

    // R2 enable field and unused offsets
    wr(4, 8'hFF); rd(4, v); check("R2", v, 1);
    wr(4, 8'h00); rd(4, v); check("R2", v, 0);
    for (int a = 5; a < 8; a++) begin
      wr(a, 8'hFF); rd(a, v); check("R2", v, 0);
    end
    for (int a = 0; a < 4; a++) begin
      rd(a, v); check("R2", v, int'(mdl[a]));
    end

    // R6 R7 R8 mask patterns x field matches
    wr(4, 1);
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 4; a++) wr(a, int'(base[a]) | (((p >> a) & 1) << 7));
      for (int c = 0; c < 16; c++) begin
        tick(c[0] ? 8'h30 : 8'h31, c[1] ? 8'h15 : 8'h16,
             c[2] ? 8'h12 : 8'h13, c[3] ? 8'h21 : 8'h22, v);
        check(p == 0 ? "R6" : ((p == 8 || p == 12 || p == 14) ? "R7" : "R8"),
              v, int'(exp_fire(p, c)));
      end
    end

    // R9 single pulse, no fire without strobe
    for (int a = 0; a < 4; a++) wr(a, int'(base[a]));
    tick(8'h30, 8'h15, 8'h12, 8'h21, v);
    check("R9", v, 1);
    @(negedge clk_i); check("R9", int'(irq_o), 0);
    repeat (3) begin
      @(negedge clk_i); check("R9", int'(irq_o), 0);
    end

    // R10 enable gate, every-second pattern
    wr(0, 8'hB0); wr(4, 0);
    tick(8'h30, 8'h15, 8'h12, 8'h21, v);
    check("R10", v, 0);
    wr(4, 1);
    tick(8'h30, 8'h15, 8'h12, 8'h21, v);
    check("R10", v, 1);

    // R11 re-arm after accepted write
    wr(0, 8'h10);
    tick(8'h20, 8'h15, 8'h12, 8'h21, v); check("R11", v, 0);
    wr(0, 8'h20);
    tick(8'h20, 8'h15, 8'h12, 8'h21, v); check("R11", v, 1);
    wr(0, 8'h7A); // rejected, alarm stays 0x20
    tick(8'h20, 8'h15, 8'h12, 8'h21, q); check("R11", q, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule